// File: doc/BRIEF.md
# Two-Channel Converter Serial Host Controller

This block drives a 16-bit, two-channel successive-approximation converter that has a conversion-start pin and a full-duplex serial port. When the host logic pulses a request, the controller raises the start line and holds it high for a programmable number of system clocks while the converter works. It then lowers the start line, which also acts as the frame select, and produces exactly sixteen serial clocks.

During those sixteen clocks it sends a 2-bit multiplexer configuration word and collects the 16-bit result of the conversion that has just finished. The configuration sent in a frame selects the *next* conversion. Each returned result is therefore tagged with the configuration sent one frame earlier. A flag marks the first result after reset, whose configuration is unknown. A divider of the system clock sets the serial clock rate.

Configuration encoding on `cfg_i` is bit 1 = single-ended select and bit 0 = odd/sign select. The pairs are:

- 10: channel 0 against ground.
- 11: channel 1 against ground.
- 00: channel 0 minus channel 1.
- 01: channel 1 minus channel 0.

Top module: `adc2ch_host`

## Requirements
- R1: While reset is high and right after it, `conv_o`, `sck_o`, `busy_o` and `valid_o` are all low.
- R2: A request taken while idle sets `conv_o` and `busy_o` high at the next clock edge. `conv_o` then stays high for exactly CONV_CYCLES system clocks.
- R3: `sck_o` is low whenever `conv_o` is high and whenever `busy_o` is low, so it idles low.
- R4: Each frame produces exactly 16 rising edges of `sck_o`, never more.
- R5: On `sdi_o`, the first rising `sck_o` edge of a frame sees `cfg_i[1]` (single-ended select) and the second sees `cfg_i[0]` (odd/sign). The value is driven before the first rising edge. The remaining 14 rising edges see 0.
- R6: `sdo_i` is sampled on each rising `sck_o` edge. The first bit sampled becomes bit 15 of `data_o`, so the result is taken most significant bit first.
- R7: `valid_o` is a one-cycle pulse issued after the 16th falling `sck_o` edge. `busy_o` is low in the cycle in which `valid_o` is high.
- R8: With each result, `data_cfg_o` gives the configuration sent in the previous frame. `data_cfg_ok_o` is 0 for the first result after reset and 1 afterwards.
- R9: A request made while `busy_o` is high is ignored. It starts no extra frame, and its `cfg_i` value is never sent.
- R10: Each high phase of `sck_o` lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a conversion and frame (taken when idle) |
| cfg_i | input | 2 | Multiplexer configuration for the next conversion |
| busy_o | output | 1 | High from the accepted request until the result pulse |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 16 | Captured conversion result |
| data_cfg_o | output | 2 | Configuration that produced `data_o` |
| data_cfg_ok_o | output | 1 | `data_cfg_o` is meaningful (not the first result) |
| conv_o | output | 1 | Conversion start / frame select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
The bench builds the controller with CONV_CYCLES = 5 and HALF_DIV = 2. The short conversion window lets the bench fire a stray request while the start line is still high, and another during the shift phase. Six frames, some of them back to back, then fit in a few hundred cycles. A two-cycle half-period separates a correctly divided serial clock from one that toggles every system clock. A converter model with shifted data patterns (single top bit, single bottom bit, all ones, all zeros) exposes any bit-order or off-by-one capture error.

// File: rtl/adc2ch_pkg.sv
package adc2ch_pkg;

    localparam int RES_W = 16;
    localparam int CFG_W = 2;

    typedef struct packed {
        logic sgl;   // single-ended select, sent first
        logic odd;   // odd/sign select, sent second
    } mux_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_XFER
    } seq_state_t;

    typedef struct packed {
        logic [RES_W-1:0] data;
        mux_cfg_t         cfg;
        logic             cfg_ok;
    } result_t;

    // word loaded into the transmit register: configuration then zeros
    function automatic logic [RES_W-1:0] frame_word(input mux_cfg_t c);
        return {c.sgl, c.odd, {(RES_W-CFG_W){1'b0}}};
    endfunction

endpackage

// File: rtl/adc2ch_sckgen.sv
module adc2ch_sckgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sck,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] div;
    logic          wrap;

    assign wrap    = run && (div == DW'(HALF_DIV - 1));
    assign rise_ev = wrap && !sck;
    assign fall_ev = wrap && sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div <= '0;
            sck <= 1'b0;
        end else if (wrap) begin
            div <= '0;
            sck <= ~sck;
        end else begin
            div <= div + DW'(1);
        end
    end

    // R3: an idle generator never leaves the clock high
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> !sck);

endmodule

// File: rtl/adc2ch_shifter.sv
module adc2ch_shifter #(
    parameter int W = adc2ch_pkg::RES_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         rise_ev,
    input  logic         fall_ev,
    input  logic         sdo_i,
    output logic         sdi_o,
    output logic [W-1:0] rx_word,
    output logic         all_in
);
    localparam int BW = $clog2(W + 1);

    logic [W-1:0]  tx;
    logic [BW-1:0] nbits;

    assign sdi_o  = tx[W-1];
    assign all_in = (nbits == BW'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx      <= '0;
            rx_word <= '0;
            nbits   <= '0;
        end else if (load) begin
            tx      <= load_word;
            rx_word <= '0;
            nbits   <= '0;
        end else begin
            if (rise_ev) begin
                rx_word <= {rx_word[W-2:0], sdo_i};
                nbits   <= nbits + BW'(1);
            end
            if (fall_ev) begin
                tx <= {tx[W-2:0], 1'b0};
            end
        end
    end

    // R4: no rising serial edge beyond the result width
    assert_no_extra_rise_R4: assert property (@(posedge clk) disable iff (rst)
        rise_ev |-> (nbits < BW'(W)));

    // R5: after the two configuration bits the data line is held at zero
    assert_sdi_tail_R5: assert property (@(posedge clk) disable iff (rst)
        (rise_ev && nbits >= BW'(2)) |-> !sdi_o);

endmodule

// File: rtl/adc2ch_seq.sv
module adc2ch_seq
    import adc2ch_pkg::*;
#(
    parameter int CONV_CYCLES = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  mux_cfg_t            cfg_in,
    input  logic                fall_ev,
    input  logic                all_in,
    input  logic [RES_W-1:0]    rx_word,
    output logic                load,
    output logic                conv,
    output logic                busy,
    output logic                run,
    output logic                valid,
    output result_t             res
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    mux_cfg_t      cur_cfg;
    mux_cfg_t      prev_cfg;
    logic          prev_ok;
    logic          done;

    assign load = (state == ST_IDLE) && req;
    assign run  = (state == ST_XFER);
    assign done = run && fall_ev && all_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            conv     <= 1'b0;
            busy     <= 1'b0;
            valid    <= 1'b0;
            res      <= '0;
            cur_cfg  <= '0;
            prev_cfg <= '0;
            prev_ok  <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state   <= ST_CONV;
                        conv    <= 1'b1;
                        busy    <= 1'b1;
                        cnt     <= '0;
                        cur_cfg <= cfg_in;
                    end
                end
                ST_CONV: begin
                    if (cnt == CW'(CONV_CYCLES - 1)) begin
                        conv  <= 1'b0;
                        state <= ST_XFER;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_XFER: begin
                    if (done) begin
                        state    <= ST_IDLE;
                        busy     <= 1'b0;
                        valid    <= 1'b1;
                        res      <= '{data: rx_word, cfg: prev_cfg, cfg_ok: prev_ok};
                        prev_cfg <= cur_cfg;
                        prev_ok  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: result strobe lasts one cycle and coincides with busy low
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> !busy);

    // R9: the latched configuration cannot change while a frame is in flight
    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> $stable(cur_cfg));

endmodule

// File: rtl/adc2ch_host.sv
module adc2ch_host
    import adc2ch_pkg::*;
#(
    parameter int CONV_CYCLES = 100,
    parameter int HALF_DIV    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES_W-1:0] data_o,
    output logic [CFG_W-1:0] data_cfg_o,
    output logic             data_cfg_ok_o,
    output logic             conv_o,
    output logic             sck_o,
    output logic             sdi_o,
    input  logic             sdo_i
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam int HW = $clog2(HALF_DIV + 1);

    mux_cfg_t         cfg_s;
    logic             load, run, rise_ev, fall_ev, all_in;
    logic [RES_W-1:0] rx_word;
    result_t          res;

    assign cfg_s         = mux_cfg_t'(cfg_i);
    assign data_o        = res.data;
    assign data_cfg_o    = res.cfg;
    assign data_cfg_ok_o = res.cfg_ok;

    adc2ch_seq #(.CONV_CYCLES(CONV_CYCLES)) seq_i (
        .clk(clk), .rst(rst), .req(req_i), .cfg_in(cfg_s),
        .fall_ev(fall_ev), .all_in(all_in), .rx_word(rx_word),
        .load(load), .conv(conv_o), .busy(busy_o), .run(run),
        .valid(valid_o), .res(res)
    );

    adc2ch_sckgen #(.HALF_DIV(HALF_DIV)) sck_i (
        .clk(clk), .rst(rst), .run(run),
        .sck(sck_o), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    adc2ch_shifter #(.W(RES_W)) shf_i (
        .clk(clk), .rst(rst), .load(load), .load_word(frame_word(cfg_s)),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .sdo_i(sdo_i),
        .sdi_o(sdi_o), .rx_word(rx_word), .all_in(all_in)
    );

    // run-length counters watching the pins
    logic [CW-1:0] conv_len;
    logic [HW-1:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_len <= '0;
            hi_len   <= '0;
        end else begin
            conv_len <= conv_o ? conv_len + CW'(1) : '0;
            hi_len   <= sck_o  ? hi_len + HW'(1)   : '0;
        end
    end

    // R2: start line held for exactly the conversion time
    assert_conv_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_o) |-> (conv_len == CW'(CONV_CYCLES)));

    // R3: serial clock quiet during conversion
    assert_quiet_conv_R3: assert property (@(posedge clk) disable iff (rst)
        conv_o |-> !sck_o);

    // R10: serial clock high phase equals the half-period
    assert_sck_half_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sck_o) |-> (hi_len == HW'(HALF_DIV)));

endmodule

// File: tb/adc2ch_host_tb_top.sv
module adc2ch_host_tb_top;
    localparam int CONV = 5;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [1:0]  cfg_i = 2'b00;
    logic        busy_o, valid_o, data_cfg_ok_o, conv_o, sck_o, sdi_o;
    logic [15:0] data_o;
    logic [1:0]  data_cfg_o;
    logic        sdo_i;

    always #10 clk = ~clk;

    adc2ch_host #(.CONV_CYCLES(CONV), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .cfg_i(cfg_i),
        .busy_o(busy_o), .valid_o(valid_o), .data_o(data_o),
        .data_cfg_o(data_cfg_o), .data_cfg_ok_o(data_cfg_ok_o),
        .conv_o(conv_o), .sck_o(sck_o), .sdi_o(sdi_o), .sdo_i(sdo_i)
    );

    typedef struct {
        logic [15:0] data;
        logic [1:0]  cfg;
        logic        ok;
        logic [1:0]  sent;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] model_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [1:0]  prev_cfg = 2'b00;
    logic        prev_ok = 1'b0;
    bit          finished = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // converter model
    logic [15:0] sh = 16'h0;
    int          rises = 0;
    logic [1:0]  got = 2'b00;
    logic        tail_bad = 1'b0;
    logic        prev_conv = 1'b0;
    logic        prev_sck = 1'b0;
    bit          armed = 0;

    assign sdo_i = sh[15];

    always @(conv_o or sck_o) begin
        if (armed && prev_conv && !conv_o) begin
            sh       = (model_q.size() != 0) ? model_q.pop_front() : 16'hDEAD;
            rises    = 0;
            got      = 2'b00;
            tail_bad = 1'b0;
        end else if (armed && prev_sck && !sck_o && !conv_o) begin
            sh = {sh[14:0], 1'b0};
        end
        prev_conv = conv_o;
        prev_sck  = sck_o;
    end

    always @(posedge sck_o) begin
        if (rises < 2) got = {got[0], sdi_o};
        else if (sdi_o) tail_bad = 1'b1;
        rises++;
    end

    // monitor / scoreboard
    int   clen = 0;
    int   hlen = 0;
    logic prev_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (conv_o) clen++;
            else if (clen != 0) begin
                chk("R2", "start line high length", clen, CONV);
                clen = 0;
            end
            if (sck_o) hlen++;
            else if (hlen != 0) begin
                chk("R10", "sck high phase length", hlen, HALF);
                hlen = 0;
            end
            if (sck_o && (conv_o || !busy_o)) chk("R3", "sck high outside shift", 1, 0);
            if (valid_o && prev_valid) chk("R7", "valid longer than one cycle", 1, 0);
            if (valid_o) begin
                if (exp_q.size() == 0) chk("R7", "unexpected result strobe", 1, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R6", "result data", data_o, e.data);
                    chk("R8", "result configuration", data_cfg_o, e.cfg);
                    chk("R8", "configuration known flag", data_cfg_ok_o, e.ok);
                    chk("R7", "busy during strobe", busy_o, 0);
                    chk("R4", "rising sck edges in frame", rises, 16);
                    chk("R5", "configuration bits sent", got, e.sent);
                    chk("R5", "nonzero data after config", tail_bad, 0);
                end
            end
            prev_valid = valid_o;
        end
    end

    task automatic run_frame(input logic [1:0] c, input logic [15:0] d, input bit poke);
        exp_t e;
        model_q.push_back(d);
        e.data = d; e.cfg = prev_cfg; e.ok = prev_ok; e.sent = c;
        exp_q.push_back(e);
        prev_cfg = c;
        prev_ok  = 1'b1;
        @(negedge clk);
        req_i = 1'b1; cfg_i = c;
        @(negedge clk);
        req_i = 1'b0; cfg_i = ~c;
        chk("R2", "start line after request", conv_o, 1);
        chk("R2", "busy after request", busy_o, 1);
        if (poke) begin
            // R9: stray requests during conversion and during the shift
            @(negedge clk); req_i = 1'b1;
            @(negedge clk); req_i = 1'b0;
            while (conv_o) @(negedge clk);
            repeat (3) @(negedge clk);
            req_i = 1'b1;
            @(negedge clk); req_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk("R9", "no frame from ignored request (conv)", conv_o, 0);
            chk("R9", "no frame from ignored request (busy)", busy_o, 0);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 50000);
            summary();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", "conv_o in reset", conv_o, 0);
        chk("R1", "sck_o in reset", sck_o, 0);
        chk("R1", "busy_o in reset", busy_o, 0);
        chk("R1", "valid_o in reset", valid_o, 0);
        rst = 1'b0;
        armed = 1;
        @(negedge clk);
        chk("R1", "busy_o after reset", busy_o, 0);
        chk("R3", "sck_o idle after reset", sck_o, 0);

        run_frame(2'b10, 16'hA5C3, 0);   // first result flagged unknown (R8)
        run_frame(2'b11, 16'h0001, 1);
        run_frame(2'b00, 16'h8000, 0);
        run_frame(2'b01, 16'hFFFF, 1);
        run_frame(2'b10, 16'h0000, 0);
        run_frame(2'b11, 16'h7E81, 0);

        repeat (10) @(negedge clk);
        chk("R7", "outstanding results", exp_q.size(), 0);
        chk("R4", "sck idle after last frame", sck_o, 0);
        finished = 1;
        summary();
    end

endmodule